// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block turns an asynchronous serial line into characters. A baud divider outside the block supplies a one-clock tick at sixteen times the bit rate. The block passes the raw line through a synchronizer and looks for a falling edge. It checks that the start bit is genuine, samples every later bit at its centre, and rebuilds a 5 to 8 bit character. It also checks the optional parity bit and the first stop bit.

Each finished character goes to a downstream receive buffer as a single push pulse. The pulse carries the data byte and three flags that belong to that character alone: parity error, framing error and break. When the buffer reports full, the character is dropped and an overrun pulse is raised instead. A line held low for a whole frame is reported once, as a zero character marked as break. The receiver then stays silent until the line has gone high and a new valid start bit arrives.

Top module: `uart_rx_engine`

## Requirements
- R1: `word_len_i` selects the number of data bits: 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first, and bits of `push_data_o` above the word length are zero.
- R2: When `par_en_i` is 1, one parity bit follows the last data bit. Counted over the data bits plus the parity bit, the number of ones must be even when `par_even_i` is 1 and odd when it is 0. A mismatch sets `push_perr_o` for that character only. With parity off, `push_perr_o` is 0.
- R3: Only the first stop bit is sampled. If it is low and the frame is not a break, `push_ferr_o` is 1 for that character.
- R4: A start bit is accepted only if the line is still low at the 8th tick after the falling edge. A shorter low pulse produces no character. Every later bit is sampled 16 ticks after the previous sample.
- R5: Each character is delivered as a one-clock `push_o` pulse. The data and all three flags are valid in that same cycle.
- R6: A frame in which the start bit, all data bits, the parity bit (if enabled) and the stop bit are all low is a break. It is pushed as data 0 with `push_brk_o`=1, `push_perr_o`=0 and `push_ferr_o`=0.
- R7: After a break, nothing more is pushed, however long the line stays low. The receiver starts again only after the line returns high and a valid start bit follows.
- R8: If `buf_full_i` is 1 in the cycle a character completes, there is no push and `ovr_o` pulses for one clock. Otherwise there is a push and no overrun.
- R9: After reset, `push_o` and `ovr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-clock pulse at 16x the bit rate |
| rxd_i | input | 1 | Raw serial input, idle high |
| word_len_i | input | 2 | Data bit count code (R1) |
| par_en_i | input | 1 | Parity bit present and checked |
| par_even_i | input | 1 | 1 = even parity, 0 = odd parity |
| buf_full_i | input | 1 | Receive buffer cannot accept a push |
| push_o | output | 1 | Character push strobe |
| push_data_o | output | 8 | Received character |
| push_perr_o | output | 1 | Parity error of this character |
| push_ferr_o | output | 1 | Framing error of this character |
| push_brk_o | output | 1 | Character is a break marker |
| ovr_o | output | 1 | Character dropped because the buffer was full |

## Verification
Break completion and buffer-full rejection can happen in the same cycle. The bench provokes this by holding the line low for several frame times while `buf_full_i` is held high. The expected result is one overrun pulse, no push, and the break lockout still in force: no overrun or push follows while the line stays low. A normal frame sent after the line returns high, with the buffer free, must then be pushed with the correct data.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BRK
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic fall_o
);
  // chain[STAGES-1] is the synchronized level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain <= '1;
    else         chain <= {chain[STAGES-1:0], d_i};
  end

  assign q_o    = chain[STAGES-1];
  assign fall_o = chain[STAGES] & ~chain[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          fall_i,
  input  logic [1:0]    wl_i,
  input  logic          par_en_i,
  input  logic          par_even_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o
);
  localparam int CW = $clog2(OSR);
  localparam int IW = $clog2(DW);
  localparam logic [CW-1:0] HALF = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] FULL = CW'(OSR - 1);

  rx_state_e     state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic          par_acc, any_one;
  logic [IW-1:0] last_idx;
  logic          at_mid;

  assign last_idx = IW'(wl_i) + IW'(4);
  assign at_mid   = tick_i && (cnt == FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      sh      <= '0;
      par_acc <= 1'b0;
      any_one <= 1'b0;
      done_o  <= 1'b0;
      data_o  <= '0;
      perr_o  <= 1'b0;
      ferr_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && state != ST_IDLE && state != ST_BRK) cnt <= cnt + 1'b1;
      unique case (state)
        ST_IDLE: if (fall_i) begin
          state <= ST_START;
          cnt   <= '0;
        end
        ST_START: if (tick_i && cnt == HALF) begin
          cnt     <= '0;
          idx     <= '0;
          sh      <= '0;
          par_acc <= 1'b0;
          any_one <= 1'b0;
          state   <= rx_i ? ST_IDLE : ST_DATA;
        end
        ST_DATA: if (at_mid) begin
          sh[idx] <= rx_i;
          par_acc <= par_acc ^ rx_i;
          any_one <= any_one | rx_i;
          idx     <= idx + 1'b1;
          if (idx == last_idx) state <= par_en_i ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (at_mid) begin
          par_acc <= par_acc ^ rx_i;
          any_one <= any_one | rx_i;
          state   <= ST_STOP;
        end
        ST_STOP: if (at_mid) begin
          done_o <= 1'b1;
          if (!rx_i && !any_one) begin
            data_o <= '0;
            perr_o <= 1'b0;
            ferr_o <= 1'b0;
            brk_o  <= 1'b1;
            state  <= ST_BRK;
          end else begin
            data_o <= sh;
            perr_o <= par_en_i & (par_acc ^ ~par_even_i);
            ferr_o <= ~rx_i;
            brk_o  <= 1'b0;
            state  <= ST_IDLE;
          end
        end
        ST_BRK: if (rx_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_START_HELD_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rx_i)); // R4
  AST_BRK_EXIT_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE && $past(state) == ST_BRK) |-> $past(rx_i)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
endmodule

// File: rtl/rx_push_ctl.sv
module rx_push_ctl #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          perr_i,
  input  logic          ferr_i,
  input  logic          brk_i,
  input  logic          full_i,
  output logic          push_o,
  output logic [DW-1:0] data_o,
  output logic          perr_o,
  output logic          ferr_o,
  output logic          brk_o,
  output logic          ovr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      push_o <= 1'b0;
      ovr_o  <= 1'b0;
      data_o <= '0;
      perr_o <= 1'b0;
      ferr_o <= 1'b0;
      brk_o  <= 1'b0;
    end else begin
      push_o <= done_i & ~full_i;
      ovr_o  <= done_i & full_i;
      if (done_i && !full_i) begin
        data_o <= data_i;
        perr_o <= perr_i;
        ferr_o <= ferr_i;
        brk_o  <= brk_i;
      end
    end
  end

  AST_PUSH_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !$past(full_i)); // R8
  AST_OVR_ON_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |-> $past(full_i)); // R8
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine #(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] word_len_i,
  input  logic       par_en_i,
  input  logic       par_even_i,
  input  logic       buf_full_i,
  output logic       push_o,
  output logic [7:0] push_data_o,
  output logic       push_perr_o,
  output logic       push_ferr_o,
  output logic       push_brk_o,
  output logic       ovr_o
);
  localparam int DW = 8;

  logic          rx_s, rx_fall;
  logic          f_done, f_perr, f_ferr, f_brk;
  logic [DW-1:0] f_data;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rxd_i),
    .q_o   (rx_s),
    .fall_o(rx_fall)
  );

  rx_frame_fsm #(.OSR(OSR), .DW(DW)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rx_i      (rx_s),
    .fall_i    (rx_fall),
    .wl_i      (word_len_i),
    .par_en_i  (par_en_i),
    .par_even_i(par_even_i),
    .done_o    (f_done),
    .data_o    (f_data),
    .perr_o    (f_perr),
    .ferr_o    (f_ferr),
    .brk_o     (f_brk)
  );

  rx_push_ctl #(.DW(DW)) u_push (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_i(f_done),
    .data_i(f_data),
    .perr_i(f_perr),
    .ferr_i(f_ferr),
    .brk_i (f_brk),
    .full_i(buf_full_i),
    .push_o(push_o),
    .data_o(push_data_o),
    .perr_o(push_perr_o),
    .ferr_o(push_ferr_o),
    .brk_o (push_brk_o),
    .ovr_o (ovr_o)
  );

  AST_BRK_IS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && push_brk_o) |-> (push_data_o == '0 && !push_perr_o && !push_ferr_o)); // R6
  AST_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ((push_data_o >> (4'(word_len_i) + 4'd5)) == '0)); // R1
  AST_NO_PERR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && !par_en_i) |-> !push_perr_o); // R2
endmodule

// File: tb/tb_uart_rx_engine.sv
module tb_uart_rx_engine;
  localparam int BITCLK = 64;  // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i;
  logic       rxd_i = 1'b1;
  logic [1:0] word_len_i = 2'd3;
  logic       par_en_i = 1'b0;
  logic       par_even_i = 1'b0;
  logic       buf_full_i = 1'b0;
  logic       push_o, push_perr_o, push_ferr_o, push_brk_o, ovr_o;
  logic [7:0] push_data_o;

  logic [1:0] tdiv = '0;
  int n_chk = 0, n_fail = 0;
  int pcnt = 0, ocnt = 0;
  logic [7:0] l_data;
  logic l_perr, l_ferr, l_brk;

  always #2 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign tick_i = (tdiv == 2'd3);

  uart_rx_engine dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .rxd_i(rxd_i),
    .word_len_i(word_len_i), .par_en_i(par_en_i), .par_even_i(par_even_i),
    .buf_full_i(buf_full_i), .push_o(push_o), .push_data_o(push_data_o),
    .push_perr_o(push_perr_o), .push_ferr_o(push_ferr_o),
    .push_brk_o(push_brk_o), .ovr_o(ovr_o)
  );

  always @(negedge clk) begin
    if (push_o) begin
      pcnt++;
      l_data = push_data_o; l_perr = push_perr_o;
      l_ferr = push_ferr_o; l_brk = push_brk_o;
    end
    if (ovr_o) ocnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int clocks);
    rxd_i = v;
    repeat (clocks) @(negedge clk);
  endtask

  function automatic logic [7:0] wmask(input logic [1:0] wl);
    return 8'hFF >> (3 - wl);
  endfunction

  // sends one frame and checks the outcome against the model
  task automatic frame(input logic [7:0] d, input logic [1:0] wl, input logic pen,
                       input logic pev, input logic flip, input logic stopv,
                       input logic full, input string req);
    logic [7:0] m, dm;
    logic pb, is_brk;
    int p0, o0;
    m  = wmask(wl);
    dm = d & m;
    pb = (pev ? ^dm : ~^dm) ^ flip;
    is_brk = !stopv && dm == 0 && (!pen || !pb);
    word_len_i = wl; par_en_i = pen; par_even_i = pev; buf_full_i = full;
    p0 = pcnt; o0 = ocnt;
    hold(1'b0, BITCLK);
    for (int i = 0; i < 5 + int'(wl); i++) hold(d[i], BITCLK);
    if (pen) hold(pb, BITCLK);
    hold(stopv, BITCLK);
    hold(1'b1, 2 * BITCLK);
    if (full) begin
      chk(pcnt == p0, {req, " R8 dropped"}, pcnt - p0, 0);
      chk(ocnt == o0 + 1, {req, " R8 overrun"}, ocnt - o0, 1);
    end else begin
      chk(pcnt == p0 + 1 && ocnt == o0, {req, " R5 one push"}, pcnt - p0, 1);
      chk(l_data == (is_brk ? 8'h00 : dm), {req, " R1 data"}, l_data, is_brk ? 0 : dm);
      chk(l_perr == (!is_brk && pen && flip), {req, " R2 perr"}, l_perr, !is_brk && pen && flip);
      chk(l_ferr == (!is_brk && !stopv), {req, " R3 ferr"}, l_ferr, !is_brk && !stopv);
      chk(l_brk == is_brk, {req, " R6 brk"}, l_brk, is_brk);
    end
    buf_full_i = 1'b0;
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int p0, o0;
    void'($urandom(32'h5EED_1234));
    repeat (5) @(negedge clk);
    chk(push_o == 0 && ovr_o == 0, "R9 reset outputs", {push_o, ovr_o}, 0);
    rst_ni = 1'b1;
    hold(1'b1, 2 * BITCLK);

    frame(8'hA5, 2'd3, 0, 0, 0, 1, 0, "8bit");
    frame(8'hFF, 2'd0, 0, 0, 0, 1, 0, "5bit mask");
    frame(8'h6B, 2'd1, 0, 0, 0, 1, 0, "6bit");
    frame(8'h4D, 2'd2, 1, 1, 0, 1, 0, "even ok");
    frame(8'h4D, 2'd2, 1, 0, 1, 1, 0, "odd bad");
    frame(8'h3C, 2'd3, 1, 0, 0, 1, 0, "odd ok");
    frame(8'h3C, 2'd3, 0, 0, 0, 0, 0, "stop low");
    frame(8'h81, 2'd3, 0, 0, 0, 1, 1, "full");

    // R4: low pulse shorter than half a bit is no start
    p0 = pcnt; o0 = ocnt;
    hold(1'b0, 20);
    hold(1'b1, 3 * BITCLK);
    chk(pcnt == p0 && ocnt == o0, "R4 glitch rejected", pcnt - p0, 0);
    frame(8'h5A, 2'd3, 0, 0, 0, 1, 0, "after glitch R4");

    // R6/R7: long break gives one zero character only
    word_len_i = 2'd3; par_en_i = 1'b0;
    p0 = pcnt;
    hold(1'b0, 36 * BITCLK);
    chk(pcnt == p0 + 1, "R7 single break push", pcnt - p0, 1);
    chk(l_brk == 1 && l_data == 0, "R6 break char", {l_brk, l_data}, 9'h100);
    hold(1'b1, 2 * BITCLK);
    chk(pcnt == p0 + 1, "R7 no push on release", pcnt - p0, 1);
    frame(8'hC3, 2'd3, 0, 0, 0, 1, 0, "after break R7");

    // break completes while buffer full: overrun, lockout kept
    buf_full_i = 1'b1;
    p0 = pcnt; o0 = ocnt;
    hold(1'b0, 30 * BITCLK);
    chk(pcnt == p0, "R8 break dropped", pcnt - p0, 0);
    chk(ocnt == o0 + 1, "R8 R7 one overrun", ocnt - o0, 1);
    buf_full_i = 1'b0;
    hold(1'b0, 20 * BITCLK);
    chk(pcnt == p0 && ocnt == o0 + 1, "R7 lockout after full break", pcnt - p0, 0);
    hold(1'b1, 2 * BITCLK);
    frame(8'h96, 2'd3, 1, 1, 0, 1, 0, "after full break R7");

    for (int k = 0; k < 40; k++) begin
      logic [7:0] d;
      logic [1:0] wl;
      logic pen, pev, flip, stopv, full;
      d     = 8'($urandom);
      wl    = 2'($urandom);
      pen   = 1'($urandom);
      pev   = 1'($urandom);
      flip  = ($urandom % 4) == 0;
      stopv = ($urandom % 5) != 0;
      full  = ($urandom % 5) == 0;
      if (($urandom % 8) == 0) d = 8'h00;
      frame(d, wl, pen, pev, flip, stopv, full, "random");
    end
    summary();
  end
endmodule